// File: doc/BRIEF.md
# Asynchronous Memory-Bus Write Qualifier

This block watches the three active-low strobes of an asynchronous byte-wide memory bus: chip select, write strobe and output enable. A free-running oversampling clock samples them. All three strobes and the bus address and data pass through a synchronizer. The strobes then pass through a stability filter. The address and data pass through a delay line of the same length as the filter, so they stay aligned with the filtered strobes. A write window is open while chip select and write strobe are both low and output enable is high. Either strobe may be the one that opens or closes the window.

The block captures the address at the moment the window opens, which is when the later of the two strobes falls. It captures the data from the last sample before the window closes, which is when the earlier of the two strobes rises. When a window closes cleanly, the block issues a single-clock command pulse carrying that address and data. No command is issued in these cases:
- a strobe pulse shorter than the filter threshold;
- a window that is ended by output enable going low;
- a window during which the supply-lockout input was high;
- a window that was already open when reset was released.

The command output is a one-clock strobe without back-pressure. The external bus cannot be stalled, so the downstream decoder must accept every pulse in the cycle it appears.

Top module: `memwr_qualifier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd_valid` is 0 and `cmd_addr` and `cmd_data` are all zeros.
- R2: Write-strobe-controlled write: chip select falls first, write strobe falls later and rises first, and output enable stays high. This produces `cmd_valid`=1 exactly SYNC_STAGES+GLITCH_CYC+1 rising clock edges after the write strobe rises. The edges are counted from the first edge at which the rise is sampled.
- R3: Chip-select-controlled write: write strobe falls first, chip select falls later and rises first. This produces `cmd_valid` with the same latency as R2, counted from the chip-select rise.
- R4: `cmd_addr` equals the bus address present when the later strobe fell. Address changes made after that point, while the window is still open, have no effect.
- R5: `cmd_data` equals the bus data present on the last sample before the earlier strobe rose. Data changes made together with or after that rise have no effect.
- R6: A low pulse on write strobe or chip select that lasts fewer than GLITCH_CYC clock periods produces no command. A high pulse on output enable of that length inside a window does not abort the window.
- R7: A window that ends because output enable went low produces no command.
- R8: If `lockout` is 1 on any clock edge while a window is open, or on the edge that opens it, that window produces no command.
- R9: If chip select and write strobe are already low with output enable high when reset is released, the window that closes first produces no command. The next complete window is accepted.
- R10: Every accepted window produces exactly one `cmd_valid` pulse, and that pulse is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ce_n | input | 1 | Bus chip select, active low, asynchronous |
| we_n | input | 1 | Bus write strobe, active low, asynchronous |
| oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address, asynchronous |
| bus_data | input | DATA_W | Bus write data, asynchronous |
| lockout | input | 1 | Supply-low lockout, high blocks writes, synchronous to clk |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_addr | output | ADDR_W | Address of the accepted write, held until the next one |
| cmd_data | output | DATA_W | Data of the accepted write, held until the next one |

## Verification
The bench changes the strobes at falling clock edges. A strobe rise is therefore first sampled on the next rising edge. The command pulse is due SYNC_STAGES+GLITCH_CYC+1 rising edges after that, which is five edges with the defaults. The bench samples one nanosecond after that exact edge, and checks one edge later that the pulse has dropped. For writes that should be rejected, the bench checks `cmd_valid` at the same edge. It also compares a running count of pulses before and after each bus sequence. A late or extra pulse is therefore caught as well as a missing one.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/wrq_sync.sv
module wrq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wrq_delay.sv
module wrq_delay #(
  parameter int W = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_line
      logic [W-1:0] line [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else begin
          line[0] <= d;
          for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
      end
      assign q = line[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/wrq_filter.sv
module wrq_filter #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic f
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (s == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl_q <= s;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign f = lvl_q;

  // R6: the filtered level only moves to a value the raw input already held
  a_r6_filter_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s) == lvl_q));
endmodule

// File: rtl/wrq_cycle_fsm.sv
module wrq_cycle_fsm #(
  parameter int AW = 18,
  parameter int DW = 8,
  parameter int PRIME = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          oe_f,
  input  logic          lockout,
  input  logic [AW-1:0] a_al,
  input  logic [DW-1:0] d_al,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  localparam int PW = $clog2(PRIME + 1);
  localparam logic [PW-1:0] PRIME_MAX = PW'(PRIME);

  logic [PW-1:0] prime_q;
  logic          primed;
  logic          armed_q;
  logic          act, act_q;
  logic          open_q, abort_q;
  logic          start, finish;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act    = ~ce_f & ~we_f & oe_f;
  assign primed = (prime_q == PRIME_MAX);
  assign start  = act & ~act_q & armed_q;
  assign finish = open_q & ~act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prime_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (!primed) prime_q <= prime_q + 1'b1;
      if (primed && !act) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= 1'b1;
      open_q    <= 1'b0;
      abort_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      act_q     <= act;
      cmd_valid <= 1'b0;
      if (start) begin
        open_q  <= 1'b1;
        abort_q <= lockout;
        addr_q  <= a_al;
        data_q  <= d_al;
      end else if (finish) begin
        open_q <= 1'b0;
        if (oe_f && !abort_q && !lockout) begin
          cmd_valid <= 1'b1;
          cmd_addr  <= addr_q;
          cmd_data  <= data_q;
        end
      end else if (open_q) begin
        data_q <= d_al;
        if (lockout) abort_q <= 1'b1;
      end
    end
  end

  // R10: a command pulse lasts a single clock
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R7: a command only follows a window closed with output enable high
  a_r7_oe_high_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(oe_f));
  // R8: lockout on the closing edge blocks the command
  a_r8_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockout) |-> !cmd_valid);
  // R9: a window can only open once an idle bus has been observed
  a_r9_open_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(armed_q));
endmodule

// File: rtl/memwr_qualifier.sv
module memwr_qualifier
  import wrq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int GLITCH_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              lockout,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int SW = $bits(strobe_t);
  localparam int BW = ADDR_W + DATA_W;
  localparam int PRIME = SYNC_STAGES + GLITCH_CYC + 1;

  strobe_t          raw_s, syn_s, flt_s;
  logic [BW-1:0]    bus_syn, bus_al;

  assign raw_s = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

  wrq_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_s)
  );

  wrq_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_addr, bus_data}), .q(bus_syn)
  );

  wrq_delay #(.W(BW), .DEPTH(GLITCH_CYC)) u_bus_align (
    .clk(clk), .rst_n(rst_n), .d(bus_syn), .q(bus_al)
  );

  genvar gi;
  generate
    for (gi = 0; gi < SW; gi++) begin : g_flt
      wrq_filter #(.CYC(GLITCH_CYC)) u_flt (
        .clk(clk), .rst_n(rst_n), .s(syn_s[gi]), .f(flt_s[gi])
      );
    end
  endgenerate

  wrq_cycle_fsm #(.AW(ADDR_W), .DW(DATA_W), .PRIME(PRIME)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ce_f(flt_s.ce_n), .we_f(flt_s.we_n), .oe_f(flt_s.oe_n),
    .lockout(lockout),
    .a_al(bus_al[BW-1:DATA_W]), .d_al(bus_al[DATA_W-1:0]),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );
endmodule

// File: tb/memwr_qualifier_test.sv
`timescale 1ns/1ps
module memwr_qualifier_test;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int LAT = 2 + 2 + 1; // SYNC_STAGES + GLITCH_CYC + 1
  localparam int NV = 10;
  // {expect, mode, addr, data}; modes: 0 write-strobe ctl, 1 chip-select ctl,
  // 2 write-strobe glitch, 3 output enable low, 4 lockout, 5 OE glitch, 6 CS glitch
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 3'd0, 18'h2A5C3, 8'h5A},
    {1'b1, 3'd1, 18'h1F00F, 8'hA5},
    {1'b1, 3'd0, 18'h3FFFF, 8'hFF},
    {1'b1, 3'd1, 18'h00000, 8'h00},
    {1'b0, 3'd2, 18'h11111, 8'h11},
    {1'b0, 3'd6, 18'h22222, 8'h22},
    {1'b0, 3'd3, 18'h33333, 8'h33},
    {1'b0, 3'd4, 18'h04444, 8'h44},
    {1'b1, 3'd5, 18'h12345, 8'h3C},
    {1'b1, 3'd0, 18'h0BEEF, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lockout = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memwr_qualifier uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .lockout(lockout),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(posedge clk) if (rst_n && cmd_valid) pulses <= pulses + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [2:0] mode, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic exp);
    int base;
    base = pulses;
    if (mode == 3'd2 || mode == 3'd6) begin
      @(negedge clk); bus_addr = a; bus_data = d;
      if (mode == 3'd2) ce_n = 1'b0; else we_n = 1'b0;
      repeat (4) @(negedge clk);
      if (mode == 3'd2) we_n = 1'b0; else ce_n = 1'b0;
      @(negedge clk);
      if (mode == 3'd2) we_n = 1'b1; else ce_n = 1'b1;
      repeat (8) @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R6 short strobe pulse count", pulses - base, 0);
    end else begin
      @(negedge clk); bus_addr = ~a; bus_data = ~d;
      if (mode == 3'd1) we_n = 1'b0; else ce_n = 1'b0;
      repeat (4) @(negedge clk); bus_addr = a;
      @(negedge clk);
      if (mode == 3'd1) ce_n = 1'b0; else we_n = 1'b0;
      repeat (6) @(negedge clk); bus_addr = ~a; bus_data = d;
      if (mode == 3'd3 || mode == 3'd5) oe_n = 1'b0;
      if (mode == 3'd4) lockout = 1'b1;
      @(negedge clk); lockout = 1'b0;
      if (mode == 3'd5) oe_n = 1'b1;
      repeat (2) @(negedge clk); bus_data = ~d;
      if (mode == 3'd1) ce_n = 1'b1; else we_n = 1'b1;
      repeat (LAT) @(posedge clk); #1;
      if (mode == 3'd1) check("R3 pulse at latency", cmd_valid, exp);
      else if (mode == 3'd3) check("R7 oe low blocks", cmd_valid, exp);
      else if (mode == 3'd4) check("R8 lockout blocks", cmd_valid, exp);
      else if (mode == 3'd5) check("R6 oe glitch ignored", cmd_valid, exp);
      else check("R2 pulse at latency", cmd_valid, exp);
      if (exp) begin
        check("R4 address", cmd_addr, a);
        check("R5 data", cmd_data, d);
      end
      @(posedge clk); #1;
      check("R10 pulse one clock", cmd_valid, 0);
      @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
      repeat (3) @(negedge clk); oe_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R10 pulse count", pulses - base, exp);
    end
  endtask

  initial begin
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R1 reset valid", cmd_valid, 0);
    check("R1 reset addr", cmd_addr, 0);
    check("R1 reset data", cmd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle valid", cmd_valid, 0);
    repeat (10) @(negedge clk); we_n = 1'b1;
    repeat (12) @(negedge clk); ce_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 powerup window rejected", pulses, 0);
    run_vec(3'd0, 18'h15A5A, 8'h69, 1'b1); // R9: next window accepted
    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][28:26], VEC[i][25:8], VEC[i][7:0], VEC[i][29]);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule